// File: doc/BRIEF.md
# RTC Timebase: Prescaler and Update-Cycle Sequencer

This block is the timebase core of a PC-compatible real-time clock. It runs on the 32.768 kHz oscillator clock and keeps a binary divider whose full wrap is one second. A slice of that divider is tapped to make a periodic-interrupt strobe. Once per second it runs an update window for an external time/calendar counter. A status flag rises a fixed lead time before each window, so software can tell when reading the calendar is safe.

A control byte, written through a plain write strobe and always readable, holds three divider-mode bits and four rate-select bits. Its top bit returns the live update-in-progress flag and cannot be written. A set-inhibit input and a periodic-enable input come from the neighbouring control register. A host reset line leaves the control byte alone, and only the power-on reset clears it. The only data pins are the control-byte write and read, and they carry no handshake. A write takes effect at the clock edge where the strobe is sampled, so no back-pressure exists.

Top module: `rtc_timebase`

## Requirements
- R1: A clock edge with `rega_we` high stores `rega_wdata[6:4]` as the divider mode and `rega_wdata[3:0]` as the rate select. `rega_rdata` reads {flag, mode, rate}, and `rega_wdata[7]` is ignored.
- R2: Mode 3'b010 counts one step per clock. Modes 3'b110 and 3'b111 hold the divider at zero. Any other mode freezes the divider at its current count.
- R3: The first update window starts `2**(DIV_W-1)` clocks (half a second) after the divider leaves hold. After that, windows start every `2**DIV_W` clocks of counting.
- R4: The flag (`rega_rdata[7]`) rises exactly `LEAD_CLKS` clocks before `upd_active` rises.
- R5: `upd_active` stays high for `UPD_CLKS` clocks. The flag stays high through the whole window and falls on the same edge as `upd_active`.
- R6: `sec_tick` is a one-clock pulse in the first clock after a window that completed.
- R7: While `set_inhibit` is high, the flag and `upd_active` are low from the next clock on, and no window starts. A window cut short by it produces no `sec_tick`. After release, the flag waits for the next lead point.
- R8: The flag reads 0 whenever the mode is not 3'b010.
- R9: Rate code 0 gives no strobe. Codes 3 to 15 give one pulse every `2**(code-1)` counting clocks. Codes 1 and 2 give the rates of codes 8 and 9, that is 128 and 256 clocks.
- R10: `pi_pulse` is suppressed while `pie` is 0.
- R11: `host_rst` leaves the control byte unchanged and suppresses `pi_pulse` while it is high. The divider keeps counting.
- R12: Power-on reset (`por_n` low) clears the control byte, the divider and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| por_n | input | 1 | Synchronous power-on reset, active low |
| host_rst | input | 1 | Host reset. Keeps the control byte and masks the strobe |
| rega_we | input | 1 | Control-byte write strobe |
| rega_wdata | input | 8 | Control-byte write data |
| rega_rdata | output | 8 | {update flag, mode[2:0], rate[3:0]} |
| set_inhibit | input | 1 | Blocks update windows and clears the flag |
| pie | input | 1 | Periodic-interrupt enable |
| pi_pulse | output | 1 | One-clock periodic-interrupt strobe |
| upd_active | output | 1 | High during the update window |
| sec_tick | output | 1 | One-clock pulse after each completed window |

## Verification
A divider count that drifts by even one step moves the periodic strobe within at most four clocks at the fastest rate. It also moves the flag's rise and the window's start, and the clock-by-clock comparison catches the first wrong clock. A sequencer stuck in a wrong state shows within one second: it gives a window with no lead flag, a window of the wrong length, a missing or doubled tick, or a flag that stays set under inhibit or outside run mode. Stop and hold modes are checked by the shift they cause in the next window's start, measured in clocks.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;

  typedef enum logic [1:0] {
    DIV_STOP = 2'd0,
    DIV_RUN  = 2'd1,
    DIV_HOLD = 2'd2
  } div_mode_e;

  // Divider-mode code to behaviour
  function automatic div_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'b010:         decode_mode = DIV_RUN;
      3'b110, 3'b111: decode_mode = DIV_HOLD;
      default:        decode_mode = DIV_STOP;
    endcase
  endfunction

  // Rate code to log2 of the strobe period in counting clocks
  function automatic logic [3:0] rate_exp(input logic [3:0] code);
    case (code)
      4'd1:    rate_exp = 4'd7;
      4'd2:    rate_exp = 4'd8;
      default: rate_exp = code - 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/rtcb_ctrl_reg.sv
module rtcb_ctrl_reg (
  input  logic       clk,
  input  logic       por_n,
  input  logic       we,
  input  logic [6:0] wdata,
  output logic [2:0] mode_code,
  output logic [3:0] rate_code
);

  always_ff @(posedge clk) begin
    if (!por_n) begin
      mode_code <= '0;
      rate_code <= '0;
    end else if (we) begin
      mode_code <= wdata[6:4];
      rate_code <= wdata[3:0];
    end
  end

endmodule

// File: rtl/rtcb_divider.sv
module rtcb_divider
  import rtcb_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             por_n,
  input  div_mode_e        mode,
  output logic [DIV_W-1:0] cnt_nxt,
  output logic             running
);

  logic [DIV_W-1:0] cnt_q;

  always_comb begin
    case (mode)
      DIV_RUN:  cnt_nxt = cnt_q + 1'b1;
      DIV_HOLD: cnt_nxt = '0;
      default:  cnt_nxt = cnt_q;
    endcase
  end

  assign running = (mode == DIV_RUN);

  always_ff @(posedge clk) begin
    if (!por_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/rtcb_rate_tap.sv
module rtcb_rate_tap
  import rtcb_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             running,
  input  logic [3:0]       rate_code,
  input  logic             pie,
  input  logic             host_rst,
  input  logic [DIV_W-1:0] cnt_nxt,
  output logic             pi_pulse
);

  logic [3:0]       tap;
  logic [DIV_W-1:0] low_mask;
  logic             tap_hit;

  assign tap = rate_exp(rate_code);

  // Mask of the divider bits below the selected tap
  for (genvar g = 0; g < DIV_W; g++) begin : g_mask
    assign low_mask[g] = (int'(tap) > g);
  end

  assign tap_hit = ((cnt_nxt & low_mask) == '0);

  always_ff @(posedge clk) begin
    if (!por_n) pi_pulse <= 1'b0;
    else        pi_pulse <= running && (rate_code != 4'd0) && tap_hit && pie && !host_rst;
  end

endmodule

// File: rtl/rtcb_update_seq.sv
module rtcb_update_seq #(
  parameter int DIV_W     = 15,
  parameter int LEAD_CLKS = 8,
  parameter int UPD_CLKS  = 65
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             running,
  input  logic             set_inhibit,
  input  logic [DIV_W-1:0] cnt_nxt,
  output logic             uip,
  output logic             upd,
  output logic             tick
);

  localparam int HALF = 1 << (DIV_W - 1);
  localparam logic [DIV_W-1:0] ARM_PT   = DIV_W'(HALF - LEAD_CLKS);
  localparam logic [DIV_W-1:0] START_PT = DIV_W'(HALF);
  localparam logic [DIV_W-1:0] END_PT   = DIV_W'(HALF + UPD_CLKS);

  always_ff @(posedge clk) begin
    if (!por_n) begin
      uip  <= 1'b0;
      upd  <= 1'b0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (!running || set_inhibit) begin
        uip <= 1'b0;
        upd <= 1'b0;
      end else if (cnt_nxt == ARM_PT) begin
        uip <= 1'b1;
      end else if (cnt_nxt == START_PT && uip) begin
        upd <= 1'b1;
      end else if (cnt_nxt == END_PT && upd) begin
        upd  <= 1'b0;
        uip  <= 1'b0;
        tick <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import rtcb_pkg::*;
#(
  parameter int DIV_W     = 15,
  parameter int LEAD_CLKS = 8,
  parameter int UPD_CLKS  = 65
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       host_rst,
  input  logic       rega_we,
  input  logic [7:0] rega_wdata,
  output logic [7:0] rega_rdata,
  input  logic       set_inhibit,
  input  logic       pie,
  output logic       pi_pulse,
  output logic       upd_active,
  output logic       sec_tick
);

  logic [2:0]       mode_code;
  logic [3:0]       rate_code;
  div_mode_e        mode;
  logic [DIV_W-1:0] cnt_nxt;
  logic             running;
  logic             uip;
  logic             wdata_b7_unused;

  assign wdata_b7_unused = rega_wdata[7];
  assign mode = decode_mode(mode_code);

  rtcb_ctrl_reg u_ctrl (
    .clk       (clk),
    .por_n     (por_n),
    .we        (rega_we),
    .wdata     (rega_wdata[6:0]),
    .mode_code (mode_code),
    .rate_code (rate_code)
  );

  rtcb_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .por_n   (por_n),
    .mode    (mode),
    .cnt_nxt (cnt_nxt),
    .running (running)
  );

  rtcb_rate_tap #(.DIV_W(DIV_W)) u_rate (
    .clk       (clk),
    .por_n     (por_n),
    .running   (running),
    .rate_code (rate_code),
    .pie       (pie),
    .host_rst  (host_rst),
    .cnt_nxt   (cnt_nxt),
    .pi_pulse  (pi_pulse)
  );

  rtcb_update_seq #(
    .DIV_W     (DIV_W),
    .LEAD_CLKS (LEAD_CLKS),
    .UPD_CLKS  (UPD_CLKS)
  ) u_seq (
    .clk         (clk),
    .por_n       (por_n),
    .running     (running),
    .set_inhibit (set_inhibit),
    .cnt_nxt     (cnt_nxt),
    .uip         (uip),
    .upd         (upd_active),
    .tick        (sec_tick)
  );

  assign rega_rdata = {uip, mode_code, rate_code};

endmodule

// File: rtl/rtc_timebase_chk.sv
module rtc_timebase_chk #(
  parameter int LEAD_CLKS = 8
) (
  input logic       clk,
  input logic       por_n,
  input logic       host_rst,
  input logic       rega_we,
  input logic [7:0] rega_rdata,
  input logic       set_inhibit,
  input logic       pie,
  input logic       pi_pulse,
  input logic       upd_active,
  input logic       sec_tick
);

  localparam int LW = $clog2(LEAD_CLKS + 2) + 1;
  logic [LW-1:0] lead_cnt;

  // Consecutive clocks with the flag high, saturating
  always_ff @(posedge clk) begin
    if (!por_n)                lead_cnt <= '0;
    else if (!rega_rdata[7])   lead_cnt <= '0;
    else if (lead_cnt != '1)   lead_cnt <= lead_cnt + 1'b1;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    !rega_we |=> $stable(rega_rdata[6:0])); // R1
  AST_LEAD_WINDOW: assert property (@(posedge clk) disable iff (!por_n)
    $rose(upd_active) |-> (int'(lead_cnt) >= LEAD_CLKS)); // R4
  AST_UIP_COVERS_UPD: assert property (@(posedge clk) disable iff (!por_n)
    upd_active |-> rega_rdata[7]); // R5
  AST_TICK_AT_END: assert property (@(posedge clk) disable iff (!por_n)
    sec_tick |-> (!upd_active && $past(upd_active))); // R6
  AST_SET_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    set_inhibit |=> (!rega_rdata[7] && !upd_active)); // R7
  AST_IDLE_NO_UIP: assert property (@(posedge clk) disable iff (!por_n)
    (rega_rdata[6:4] != 3'b010) |=> !rega_rdata[7]); // R8
  AST_PI_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    pi_pulse |=> !pi_pulse); // R9
  AST_PI_NEEDS_PIE: assert property (@(posedge clk) disable iff (!por_n)
    pi_pulse |-> $past(pie)); // R10
  AST_PI_HOSTRST: assert property (@(posedge clk) disable iff (!por_n)
    pi_pulse |-> !$past(host_rst)); // R11

endmodule

bind rtc_timebase rtc_timebase_chk #(.LEAD_CLKS(LEAD_CLKS)) chk_i (
  .clk         (clk),
  .por_n       (por_n),
  .host_rst    (host_rst),
  .rega_we     (rega_we),
  .rega_rdata  (rega_rdata),
  .set_inhibit (set_inhibit),
  .pie         (pie),
  .pi_pulse    (pi_pulse),
  .upd_active  (upd_active),
  .sec_tick    (sec_tick)
);

// File: tb/rtc_timebase_tb_top.sv
`timescale 1ns/1ps
module rtc_timebase_tb_top;

  localparam int DIV_W = 15;
  localparam int LEAD  = 8;
  localparam int UPD   = 65;
  localparam int SEC   = 1 << DIV_W;
  localparam int HALF  = SEC / 2;

  logic       clk = 1'b0;
  logic       por_n, host_rst, rega_we, set_inhibit, pie;
  logic [7:0] rega_wdata, rega_rdata;
  logic       pi_pulse, upd_active, sec_tick;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_en = 0, done = 0;

  // Behavioural reference state
  int m_dv = 0, m_rs = 0, m_cnt = 0, m_nc, m_per;
  bit m_run, e_uip = 0, e_upd = 0, e_tick = 0, e_pi = 0;

  always #2.5 clk = ~clk;

  rtc_timebase #(.DIV_W(DIV_W), .LEAD_CLKS(LEAD), .UPD_CLKS(UPD)) dut_i (
    .clk(clk), .por_n(por_n), .host_rst(host_rst), .rega_we(rega_we),
    .rega_wdata(rega_wdata), .rega_rdata(rega_rdata), .set_inhibit(set_inhibit),
    .pie(pie), .pi_pulse(pi_pulse), .upd_active(upd_active), .sec_tick(sec_tick)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!por_n) begin
      m_dv = 0; m_rs = 0; m_cnt = 0;
      e_uip = 0; e_upd = 0; e_tick = 0; e_pi = 0;
    end else begin
      m_run = (m_dv == 2);
      if (m_run)        m_nc = (m_cnt + 1) % SEC;
      else if (m_dv >= 6) m_nc = 0;
      else              m_nc = m_cnt;
      if (m_rs == 0)      m_per = 0;
      else if (m_rs == 1) m_per = 128;
      else if (m_rs == 2) m_per = 256;
      else                m_per = 1 << (m_rs - 1);
      e_pi = m_run && (m_per != 0) && (m_nc % m_per == 0) && pie && !host_rst;
      e_tick = 0;
      if (!m_run || set_inhibit) begin
        e_uip = 0; e_upd = 0;
      end else if (m_nc == HALF - LEAD) begin
        e_uip = 1;
      end else if (m_nc == HALF && e_uip) begin
        e_upd = 1;
      end else if (m_nc == HALF + UPD && e_upd) begin
        e_upd = 0; e_uip = 0; e_tick = 1;
      end
      m_cnt = m_nc;
      if (rega_we) begin
        m_dv = int'(rega_wdata[6:4]);
        m_rs = int'(rega_wdata[3:0]);
      end
    end
  end

  // Clock-by-clock comparison against the reference
  always @(negedge clk) begin
    if (cmp_en && por_n) begin
      chk(int'(rega_rdata[6:0]) == (m_dv * 16 + m_rs), "R1 control byte", rega_rdata[6:0], m_dv * 16 + m_rs);
      chk(rega_rdata[7] == e_uip, "R4 update flag", rega_rdata[7], e_uip);
      chk(upd_active == e_upd, "R5 upd_active", upd_active, e_upd);
      chk(sec_tick == e_tick, "R6 sec_tick", sec_tick, e_tick);
      chk(pi_pulse == e_pi, "R9 pi_pulse", pi_pulse, e_pi);
    end
  end

  // Watchdog
  initial begin
    wait (cyc >= 199000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=<199000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] v);
    rega_wdata = v; rega_we = 1'b1;
    @(negedge clk);
    rega_we = 1'b0;
  endtask

  task automatic wait_upd(output int n, output int nu);
    n = 0; nu = -1;
    while (!upd_active) begin
      @(negedge clk); n++;
      if (rega_rdata[7] && nu < 0) nu = n;
    end
  endtask

  initial begin
    int n, nu, m, cnt, t1, t2, tw1, tw2;
    por_n = 0; host_rst = 0; rega_we = 0; rega_wdata = 0; set_inhibit = 0; pie = 0;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(rega_rdata == 8'h00, "R12 rdata in reset", rega_rdata, 0);
    chk({upd_active, sec_tick, pi_pulse} == 3'b000, "R12 outputs in reset", {upd_active, sec_tick, pi_pulse}, 0);
    por_n = 1; cmp_en = 1;
    @(negedge clk);

    // R1 bit 7 is not writable
    wr(8'hFF);
    chk(rega_rdata == 8'h7F, "R1 readback", rega_rdata, 8'h7F);

    // R11 host reset keeps the control byte
    host_rst = 1; repeat (3) @(negedge clk); host_rst = 0;
    chk(rega_rdata == 8'h7F, "R11 byte kept over host reset", rega_rdata, 8'h7F);

    // Release hold into run, rate code 3
    pie = 1;
    wr(8'h23);
    cnt = 0; n = 0; nu = -1;
    while (!upd_active) begin
      @(negedge clk); n++;
      if (rega_rdata[7] && nu < 0) nu = n;
      if (pi_pulse) cnt++;
    end
    t1 = cyc;
    chk(n == HALF, "R3 first update delay", n, HALF);
    chk(HALF - nu == LEAD, "R4 lead time", HALF - nu, LEAD);
    chk(cnt == HALF / 4, "R9 code 3 pulse count", cnt, HALF / 4);
    m = 0;
    while (upd_active) begin @(negedge clk); m++; end
    chk(m == UPD, "R5 window length", m, UPD);
    chk(sec_tick == 1'b1, "R6 tick after window", sec_tick, 1);
    chk(rega_rdata[7] == 1'b0, "R5 flag falls with window", rega_rdata[7], 0);

    // R9 aliased codes 1 and 2
    wr(8'h21);
    while (!pi_pulse) @(negedge clk);
    m = 0; @(negedge clk); m++;
    while (!pi_pulse) begin @(negedge clk); m++; end
    chk(m == 128, "R9 code 1 period", m, 128);
    wr(8'h22);
    while (!pi_pulse) @(negedge clk);
    m = 0; @(negedge clk); m++;
    while (!pi_pulse) begin @(negedge clk); m++; end
    chk(m == 256, "R9 code 2 period", m, 256);

    // R10 enable off
    pie = 0; cnt = 0;
    repeat (600) begin @(negedge clk); if (pi_pulse) cnt++; end
    chk(cnt == 0, "R10 no strobe with pie low", cnt, 0);
    // R11 host reset masks the strobe
    pie = 1; host_rst = 1; cnt = 0;
    repeat (600) begin @(negedge clk); if (pi_pulse) cnt++; end
    chk(cnt == 0, "R11 no strobe under host reset", cnt, 0);
    host_rst = 0;

    // R3 second window one second later
    wait_upd(n, nu);
    t2 = cyc;
    chk(t2 - t1 == SEC, "R3 window period", t2 - t1, SEC);

    // R7 inhibit across a whole lead and window
    while (m_cnt != HALF - LEAD - 20) @(negedge clk);
    set_inhibit = 1; cnt = 0;
    while (m_cnt != HALF + UPD + 10) begin
      @(negedge clk);
      if (upd_active || rega_rdata[7] || sec_tick) cnt++;
    end
    set_inhibit = 0;
    chk(cnt == 0, "R7 no window under inhibit", cnt, 0);

    // R7 inhibit in the middle of a window
    wait_upd(n, nu);
    t1 = cyc;
    repeat (5) @(negedge clk);
    set_inhibit = 1;
    @(negedge clk);
    chk({rega_rdata[7], upd_active} == 2'b00, "R7 flag and window cleared", {rega_rdata[7], upd_active}, 0);
    set_inhibit = 0; cnt = 0;
    repeat (100) begin @(negedge clk); if (sec_tick) cnt++; end
    chk(cnt == 0, "R7 no tick for cut window", cnt, 0);

    // R2 stop mode freezes the divider
    wr(8'h33); tw1 = cyc; cnt = 0;
    repeat (1000) begin @(negedge clk); if (pi_pulse || rega_rdata[7]) cnt++; end
    chk(cnt == 0, "R8 no flag or strobe while stopped", cnt, 0);
    wr(8'h23); tw2 = cyc;
    wait_upd(n, nu);
    chk(cyc - t1 == SEC + (tw2 - tw1), "R2 stop shifts next window", cyc - t1, SEC + (tw2 - tw1));

    // R2 hold resets the divider, next window half a second after release
    repeat (10) @(negedge clk);
    wr(8'h63);
    repeat (20) @(negedge clk);
    chk(rega_rdata[7] == 1'b0, "R8 flag low in hold", rega_rdata[7], 0);
    wr(8'h23);
    wait_upd(n, nu);
    chk(n == HALF, "R2 hold then release delay", n, HALF);

    repeat (5) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule